// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-ported synchronous static memory with 32-bit words. All control, address and write-data inputs are taken on the rising clock edge. Read data leaves through an output register, so the first word of a burst reaches the pins one clock later than it would from a flow-through memory. An access starts from one of two active-low address strobes. One serves a processor and always reads. The other serves a memory controller and may read or write. After that first beat, an advance input walks a two-bit counter through the other three words of the aligned four-word block. The order is linear or interleaved, chosen by a mode pin.

Writes are masked per byte lane, and a global write input forces all four lanes. The output-enable input gates the bus driver without waiting for a clock. A strobe seen while the chip enable is high deselects the device, but the last pipelined read word is still driven for one more cycle before the driver lets go. A sleep input makes the device ignore every access while it keeps its contents and its burst position. The data bus is presented as separate input, output and drive-enable pins. The enclosing pad or bus logic joins them into one shared bus.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read accepted at clock edge N drives its word on dq_out, with dq_oe high, after edge N+1 and until edge N+2, provided oe_n is low.
- R2: With ilv_mode = 0 (linear), beat k of a burst that starts at low address bits s uses low bits (s + k) mod 4. The upper address bits stay fixed, and further advances wrap within the aligned block.
- R3: With ilv_mode = 1 (interleaved), beat k uses low bits s XOR k.
- R4: Either strobe (proc_stb_n or ctrl_stb_n low) with ce_n low loads addr and restarts the burst at beat 0. When both strobes are low, the cycle is a read.
- R5: A cycle with proc_stb_n low is a read whatever the write inputs are, and memory is left unchanged.
- R6: A write happens on a controller-strobe or advance cycle when wr_all_n is low or any lane_wr_n bit is low. Bit i of lane_wr_n (active low) enables dq_in[8i+7:8i]. wr_all_n low writes all four lanes.
- R7: adv_n low with both strobes high steps the burst counter and makes an access. If no burst is active (after reset or a deselect), it makes no access.
- R8: A strobe with ce_n high deselects the device. A read accepted just before it is still driven in the cycle after the deselect edge, and dq_oe is low one cycle later.
- R9: oe_n acts on dq_oe at once, without a clock edge.
- R10: While sleep is high, no read, write, address load or counter step takes place. Contents and burst position are kept.
- R11: After reset, dq_oe is low and no burst is active.
- R12: A cycle with no access (strobes and adv_n all high) leaves dq_oe low in its output slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW ($clog2(DEPTH)) | Word address, taken on a strobe |
| proc_stb_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Chip enable, active low, sampled with a strobe |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| lane_wr_n | input | DW/8 | Per-lane write enables, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Blocks all accesses while high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | Drive enable for dq_out onto the shared bus |

## Verification
Each operation's read word is due two rising edges after the edge that accepts it. An operation that does not read has a float (dq_oe low) due in the same slot. The bench therefore keeps a one-deep queue of pending expectations and checks the previous operation's slot at each falling edge, just before it drives the next operation. Output-enable changes are checked 1 ns after the pin moves, with no clock edge in between. Write effects, sleep and ignored write enables are checked by later reads of the same words.

// File: rtl/sram_pkg.sv
// Shared constants and the burst-order helper for the pipelined burst SRAM.
// Assumes 8-bit byte lanes and a four-beat burst (two low address bits).
package sram_pkg;
    localparam int LANE_W   = 8;
    localparam int BURST_LO = 2;

    // Low address bits of beat cnt in a burst that started at start.
    function automatic logic [BURST_LO-1:0] beat_lo(
        input logic [BURST_LO-1:0] start,
        input logic [BURST_LO-1:0] cnt,
        input logic                ilv
    );
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction
endpackage

// File: rtl/sram_burst_ctrl.sv
// Burst control: decodes the strobes, the advance and the write controls
// into one access per clock, and keeps the base address and the 2-bit beat
// counter. Assumes AW >= 3. The access address is combinational, for use
// on the same edge.
module sram_burst_ctrl #(
    parameter int AW    = 8,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             adv_n,
    input  logic             ce_n,
    input  logic             wr_all_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             ilv_mode,
    input  logic             sleep,
    output logic [AW-1:0]    acc_addr,
    output logic             wr_en,
    output logic [LANES-1:0] wr_mask,
    output logic             rd_acc
);
    import sram_pkg::*;

    localparam int HI_W = AW - BURST_LO;

    logic                active;
    logic [BURST_LO-1:0] cnt;
    logic [BURST_LO-1:0] cnt_nxt;
    logic [BURST_LO-1:0] start_lo;
    logic [HI_W-1:0]     base_hi;
    logic                any_stb;
    logic                load;
    logic                desel;
    logic                step;
    logic                wr_req;
    logic                acc;
    logic                is_wr;

    // Classify this cycle: load, deselect, step or nothing.
    always_comb begin
        any_stb = ~proc_stb_n | ~ctrl_stb_n;
        load    = any_stb & ~ce_n & ~sleep;
        desel   = any_stb & ce_n & ~sleep;
        step    = ~any_stb & ~adv_n & active & ~sleep;
        wr_req  = ~wr_all_n | ~(&lane_wr_n);
        acc     = load | step;
        is_wr   = wr_req & proc_stb_n;
        cnt_nxt = cnt + 1'b1;
    end

    // Choose the access address and the kind of access.
    always_comb begin
        acc_addr = any_stb ? addr : {base_hi, beat_lo(start_lo, cnt_nxt, ilv_mode)};
        wr_en    = acc & is_wr;
        rd_acc   = acc & ~is_wr;
        wr_mask  = wr_all_n ? ~lane_wr_n : {LANES{1'b1}};
    end

    // Burst state: a load restarts, a deselect stops, an advance steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cnt      <= '0;
            start_lo <= '0;
            base_hi  <= '0;
        end else if (load) begin
            active   <= 1'b1;
            cnt      <= '0;
            start_lo <= addr[BURST_LO-1:0];
            base_hi  <= addr[AW-1:BURST_LO];
        end else if (desel) begin
            active   <= 1'b0;
        end else if (step) begin
            cnt      <= cnt_nxt;
        end
    end

    // R4: a load restarts the counter at beat 0 from the given address.
    a_r4_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active && cnt == 2'd0 && start_lo == $past(addr[1:0])));

    // R7: an advance steps the counter by exactly one.
    a_r7_adv_steps: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt == $past(cnt) + 2'd1));

    // R10: sleep freezes the burst position.
    a_r10_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (cnt == $past(cnt) && active == $past(active)));
endmodule

// File: rtl/sram_array.sv
// Storage: one memory per byte lane, written on the clock edge with a lane
// mask. Read is asynchronous from a registered address supplied by the
// output pipeline. Contents are not reset.
module sram_array #(
    parameter int AW    = 8,
    parameter int DEPTH = 256,
    parameter int LANES = 4
) (
    input  logic                            clk,
    input  logic                            wr_en,
    input  logic [LANES-1:0]                wr_mask,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [LANES*sram_pkg::LANE_W-1:0] wr_data,
    input  logic [AW-1:0]                   rd_addr,
    output logic [LANES*sram_pkg::LANE_W-1:0] rd_data
);
    import sram_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        // Self-timed write of this lane when enabled.
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                lane_mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = lane_mem[rd_addr];
    end
endmodule

// File: rtl/sram_out_pipe.sv
// Output pipeline: stage one registers the read address and a valid flag,
// stage two registers the array word. The drive enable follows stage two
// and is gated at once by the asynchronous output enable, which keeps the
// last word on the bus for one cycle after a deselect.
module sram_out_pipe #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_acc,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          oe_n,
    output logic [AW-1:0] stg_addr,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe
);
    logic stg_v;
    logic out_v;

    // Stage one: remember which word a read asked for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v    <= 1'b0;
            stg_addr <= '0;
        end else begin
            stg_v    <= rd_acc;
            stg_addr <= acc_addr;
        end
    end

    // Stage two: capture the word into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v  <= 1'b0;
            dq_out <= '0;
        end else begin
            out_v <= stg_v;
            if (stg_v) begin
                dq_out <= arr_data;
            end
        end
    end

    assign dq_oe = out_v & ~oe_n;
endmodule

// File: rtl/pipe_burst_sram.sv
// Top of the pipelined synchronous burst SRAM. It joins burst control,
// the byte-lane array and the two-stage output pipeline. The shared data
// bus is split into dq_in, dq_out and dq_oe for the pad logic above.
module pipe_burst_sram #(
    parameter int DEPTH = 256,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic                   proc_stb_n,
    input  logic                   ctrl_stb_n,
    input  logic                   adv_n,
    input  logic                   ce_n,
    input  logic                   wr_all_n,
    input  logic [DW/8-1:0]        lane_wr_n,
    input  logic                   ilv_mode,
    input  logic                   sleep,
    input  logic                   oe_n,
    input  logic [DW-1:0]          dq_in,
    output logic [DW-1:0]          dq_out,
    output logic                   dq_oe
);
    localparam int AW    = $clog2(DEPTH);
    localparam int LANES = DW / sram_pkg::LANE_W;

    logic [AW-1:0]    acc_addr;
    logic [AW-1:0]    stg_addr;
    logic             wr_en;
    logic             rd_acc;
    logic [LANES-1:0] wr_mask;
    logic [DW-1:0]    arr_data;

    sram_burst_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .adv_n      (adv_n),
        .ce_n       (ce_n),
        .wr_all_n   (wr_all_n),
        .lane_wr_n  (lane_wr_n),
        .ilv_mode   (ilv_mode),
        .sleep      (sleep),
        .acc_addr   (acc_addr),
        .wr_en      (wr_en),
        .wr_mask    (wr_mask),
        .rd_acc     (rd_acc)
    );

    sram_array #(.AW(AW), .DEPTH(DEPTH), .LANES(LANES)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_mask (wr_mask),
        .wr_addr (acc_addr),
        .wr_data (dq_in),
        .rd_addr (stg_addr),
        .rd_data (arr_data)
    );

    sram_out_pipe #(.AW(AW), .DW(DW)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_acc   (rd_acc),
        .acc_addr (acc_addr),
        .arr_data (arr_data),
        .oe_n     (oe_n),
        .stg_addr (stg_addr),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    // R5: a processor strobe never writes.
    a_r5_proc_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        !proc_stb_n |-> !wr_en);

    // R10: sleep blocks reads and writes.
    a_r10_sleep_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!wr_en && !rd_acc));

    // R1: an accepted read is driven two edges later unless output is disabled.
    a_r1_read_due: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> ##1 (dq_oe || oe_n));

    // R12: without a read, its output slot floats.
    a_r12_no_read_floats: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> ##1 !dq_oe);
endmodule

// File: tb/sim_pipe_burst_sram.sv
`timescale 1ns/1ps
module sim_pipe_burst_sram;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [AW-1:0] addr;
    logic        proc_stb_n, ctrl_stb_n, adv_n, ce_n, wr_all_n, ilv_mode, sleep, oe_n;
    logic [3:0]  lane_wr_n;
    logic [31:0] dq_in, dq_out;
    logic        dq_oe;

    always #2.5 clk = ~clk;

    pipe_burst_sram #(.DEPTH(DEPTH), .DW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
        .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .ce_n(ce_n), .wr_all_n(wr_all_n),
        .lane_wr_n(lane_wr_n), .ilv_mode(ilv_mode), .sleep(sleep), .oe_n(oe_n),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] shadow [DEPTH];
    bit          known  [DEPTH];
    bit          m_active;
    logic [1:0]  m_cnt, m_start;
    logic [AW-3:0] m_base;

    bit          cur_v, prev_v, cur_chk, prev_chk;
    logic [31:0] cur_d, prev_d;
    string       tag, cur_req, prev_req;

    bit rp, rc, ra, rce, rwa, rsl, rmd;
    logic [3:0] rlw;
    logic [7:0] rad;
    int unsigned rr;

    function automatic logic [1:0] exp_lo(logic [1:0] s, logic [1:0] k, bit ilv);
        return ilv ? (s ^ k) : (s + k);
    endfunction

    function automatic logic [31:0] pat(int a);
        return {8'hA5, 8'(a), 8'(a * 37 + 11), 8'(~a)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation: drive pins, and predict its effect and read data.
    task automatic issue(bit p, bit c, bit a, bit ce, bit wa, logic [3:0] lw,
                         bit md, bit slp, logic [7:0] ad, logic [31:0] d);
        bit any, load, desel, step, acc, iswr;
        logic [7:0] ea;
        logic [3:0] mask;
        proc_stb_n = !p; ctrl_stb_n = !c; adv_n = !a; ce_n = !ce;
        wr_all_n = !wa; lane_wr_n = ~lw; ilv_mode = md; sleep = slp;
        addr = ad; dq_in = d;
        any   = p | c;
        load  = any & ce & !slp;
        desel = any & !ce & !slp;
        step  = !any & a & m_active & !slp;
        acc   = load | step;
        iswr  = (wa | (lw != 4'd0)) & !p;
        ea    = any ? ad : {m_base, exp_lo(m_start, m_cnt + 2'd1, md)};
        mask  = wa ? 4'hF : lw;
        cur_req = tag;
        cur_v   = acc & !iswr;
        cur_chk = cur_v && known[ea];
        cur_d   = shadow[ea];
        if (acc && iswr) begin
            for (int b = 0; b < 4; b++)
                if (mask[b]) shadow[ea][b*8 +: 8] = d[b*8 +: 8];
            if (mask == 4'hF) known[ea] = 1;
        end
        if (load) begin
            m_active = 1; m_cnt = 0; m_start = ad[1:0]; m_base = ad[7:2];
        end else if (desel) m_active = 0;
        else if (step) m_cnt = m_cnt + 2'd1;
    endtask

    // Advance one clock; check the output slot of the previous operation.
    task automatic tick();
        @(negedge clk);
        if (prev_v && !oe_n) begin
            chk(dq_oe === 1'b1, prev_req, 32'(dq_oe), 32'd1);
            if (prev_chk) chk(dq_out === prev_d, prev_req, dq_out, prev_d);
        end else begin
            chk(dq_oe === 1'b0, prev_req, 32'(dq_oe), 32'd0);
        end
        prev_v = cur_v; prev_chk = cur_chk; prev_d = cur_d; prev_req = cur_req;
    endtask

    task automatic idle();
        issue(0, 0, 0, 1, 0, 4'h0, 0, 0, 8'h00, 32'h0);
        tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) begin known[i] = 0; shadow[i] = '0; end
        m_active = 0; m_cnt = 0; m_start = 0; m_base = 0;
        prev_v = 0; cur_v = 0; prev_chk = 0; cur_chk = 0; prev_d = 0; cur_d = 0;
        tag = "R11"; prev_req = "R11"; cur_req = "R11";
        rst_n = 0; oe_n = 0;
        issue(0, 0, 0, 1, 0, 4'h0, 0, 0, 8'h00, 32'h0);
        repeat (3) @(negedge clk);
        chk(dq_oe === 1'b0, "R11", 32'(dq_oe), 32'd0);
        rst_n = 1;
        // R11 / R7: advance with no burst active makes no access.
        tag = "R7";
        issue(0, 0, 1, 1, 0, 4'h0, 0, 0, 8'h00, 32'h0); tick();
        idle(); idle();

        // Fill words 0..31 with distinct patterns by controller writes (R6).
        tag = "R6";
        for (int i = 0; i < 32; i++) begin
            issue(0, 1, 0, 1, 1, 4'h0, 0, 0, 8'(i), pat(i)); tick();
        end
        idle();

        // R2: linear burst from 6 -> 6,7,4,5 then wrap to 6.
        tag = "R2";
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd6, 32'h0); tick();
        for (int k = 0; k < 4; k++) begin
            issue(0, 0, 1, 1, 0, 4'h0, 0, 0, 8'd0, 32'h0); tick();
        end
        // R3: interleaved burst from 9 -> 9,8,11,10.
        tag = "R3";
        issue(0, 1, 0, 1, 0, 4'h0, 1, 0, 8'd9, 32'h0); tick();
        for (int k = 0; k < 3; k++) begin
            issue(0, 0, 1, 1, 0, 4'h0, 1, 0, 8'd0, 32'h0); tick();
        end
        idle();

        // R5: processor strobe with writes asserted still reads.
        tag = "R5";
        issue(1, 0, 0, 1, 1, 4'hF, 0, 0, 8'd2, 32'hDEADBEEF); tick();
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd2, 32'h0); tick();
        // R4: both strobes with write controls -> read.
        tag = "R4";
        issue(1, 1, 0, 1, 1, 4'h0, 0, 0, 8'd2, 32'h12345678); tick();
        issue(0, 1, 0, 1, 0, 4'h0, 0, 0, 8'd2, 32'h0); tick();
        idle();

        // R6: lane mask 0101, then global overrides lanes.
        tag = "R6";
        issue(0, 1, 0, 1, 0, 4'b0101, 0, 0, 8'd3, 32'h11223344); tick();
        issue(0, 1, 0, 1, 0, 4'h0, 0, 0, 8'd3, 32'h0); tick();
        issue(0, 1, 0, 1, 1, 4'b0001, 0, 0, 8'd3, 32'hCAFEF00D); tick();
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd3, 32'h0); tick();
        // R6 / R7: burst write through advance, then read back the burst.
        issue(0, 1, 0, 1, 1, 4'h0, 0, 0, 8'd13, 32'hA0000000); tick();
        for (int k = 1; k < 4; k++) begin
            issue(0, 0, 1, 1, 1, 4'h0, 0, 0, 8'd0, 32'hA0000000 + k); tick();
        end
        tag = "R7";
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd13, 32'h0); tick();
        for (int k = 0; k < 3; k++) begin
            issue(0, 0, 1, 1, 0, 4'h0, 0, 0, 8'd0, 32'h0); tick();
        end

        // R8: read, deselect, advance after deselect does nothing.
        tag = "R8";
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd5, 32'h0); tick();
        issue(0, 1, 0, 0, 0, 4'h0, 0, 0, 8'd0, 32'h0); tick();
        issue(0, 0, 1, 1, 0, 4'h0, 0, 0, 8'd0, 32'h0); tick();
        idle();

        // R10: sleep blocks a write and holds the burst position.
        tag = "R10";
        issue(0, 1, 0, 1, 1, 4'h0, 0, 1, 8'd20, 32'h0BADF00D); tick();
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd20, 32'h0); tick();
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd16, 32'h0); tick();
        issue(0, 0, 1, 1, 0, 4'h0, 0, 1, 8'd0, 32'h0); tick();
        issue(0, 0, 1, 1, 0, 4'h0, 0, 0, 8'd0, 32'h0); tick();

        // R12: idle cycle after reads floats its slot.
        tag = "R12";
        idle(); idle();

        // R9: output enable acts without a clock edge.
        tag = "R9";
        issue(1, 0, 0, 1, 0, 4'h0, 0, 0, 8'd7, 32'h0); tick();
        idle();
        oe_n = 1; #1;
        chk(dq_oe === 1'b0, "R9", 32'(dq_oe), 32'd0);
        oe_n = 0; #1;
        chk(dq_oe === 1'b1, "R9", 32'(dq_oe), 32'd1);
        chk(dq_out === shadow[7], "R9", dq_out, shadow[7]);
        idle();

        // Random mix over words 0..31 (R1 and the rest).
        tag = "R1";
        for (int i = 0; i < 4000; i++) begin
            rr = $urandom_range(0, 99);
            rp = 0; rc = 0; ra = 0; rce = 1; rsl = 0; rwa = 0; rlw = 4'h0;
            rmd = 1'($urandom_range(0, 1));
            rad = 8'($urandom_range(0, 31));
            if (rr < 20) rp = 1;
            else if (rr < 40) rc = 1;
            else if (rr < 75) ra = 1;
            else if (rr < 80) begin rc = 1; rce = 0; end
            else if (rr < 85) begin ra = 1; rsl = 1; end
            else if (rr < 88) begin rp = 1; rc = 1; end
            if ($urandom_range(0, 1) == 1) begin
                rwa = ($urandom_range(0, 3) == 0);
                rlw = 4'($urandom_range(0, 15));
            end
            oe_n = ($urandom_range(0, 7) == 0);
            issue(rp, rc, ra, rce, rwa, rlw, rmd, rsl, rad, $urandom);
            tick();
        end
        oe_n = 0;
        idle(); idle();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule